// File: doc/BRIEF.md
# Switchable internal data-memory overlay

This block sits between the external-data access port of a small 8-bit CPU core and two possible targets: a 1 KB on-chip SRAM and an expansion-bus master port. Every CPU access starts with a one-cycle read or write strobe. The block decides where the access goes, runs it, and reports completion with a one-cycle ready pulse.

Software controls a single enable bit in a control register. While the bit is clear, the whole data space goes out on the expansion bus. While it is set, the low 1 KB of the data space is served by the on-chip SRAM, and the SRAM contents stay intact whenever the bit changes. Internal accesses finish one clock after the strobe. External accesses keep a bus request asserted until the bus acknowledges.

Top module: `dmem_overlay`

## Requirements
- R1: After reset, the enable bit is 0 and `cfg_rdata` reads 00h. A strobe to any address, including 0000h, then raises `bus_req`.
- R2: With the enable bit set, an access to an address in 0000h–03FFh goes to the SRAM, indexed by address bits 9:0. `bus_req` stays low for it, so internal writes never appear on the bus.
- R3: With the enable bit set, an access to 0400h or above goes to the external bus.
- R4: Setting or clearing the enable bit leaves the SRAM contents unchanged. Data written while enabled reads back the same after a disable/enable cycle with bus traffic in between.
- R5: An internal access raises `cpu_ready` in the cycle right after the strobe. For a read, `cpu_rdata` holds the stored byte in that cycle.
- R6: The enable is bit 0 of the control register. Bits 7:1 always read 0, and writing them has no effect.
- R7: An external access raises `bus_req` in the cycle after the strobe, with `bus_addr` equal to the CPU address and `bus_we` = 1 for a write. `bus_wdata` carries the CPU write data. `bus_req`, `bus_addr` and `bus_we` stay unchanged and `cpu_ready` stays low until `bus_ack` is seen high at a clock edge. In the cycle after that edge, `cpu_ready` is 1, `bus_req` is 0, and for a read `cpu_rdata` equals the `bus_rdata` sampled with the acknowledge.
- R8: A strobe that arrives while an external access is outstanding is ignored. It neither changes the pending bus request nor writes the SRAM.
- R9: A control-register write affects only accesses whose strobe comes after the write's clock edge. A strobe in the same cycle as the write still uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU data address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rdata | output | 8 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_wdata | input | 8 | Control-register write data |
| cfg_rdata | output | 8 | Control-register value |
| bus_req | output | 1 | External bus request, held until acknowledge |
| bus_we | output | 1 | External access is a write |
| bus_addr | output | 16 | External access address |
| bus_wdata | output | 8 | External write data |
| bus_rdata | input | 8 | External read data, sampled with bus_ack |
| bus_ack | input | 1 | External bus acknowledge |

## Verification
The bench builds the block with its defaults: 16-bit address, 8-bit data and a 10-bit SRAM index. With these values the full 64 KB space is reachable, so both sides of the 03FFh/0400h boundary and the top address FFFFh can be hit. A 1024-entry reference model in the bench tracks every internal write, so read-back across enable toggles is checked against real data. Bus acknowledge latencies of zero to several cycles exercise the request-hold path, and directed cases cover a strobe coinciding with an enable write and a strobe arriving during a pending bus access.

// File: rtl/dmo_pkg.sv
package dmo_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } dmo_state_e;

  localparam int unsigned EN_BIT = 0;
endpackage

// File: rtl/dmo_ctrl.sv
module dmo_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en
);
  import dmo_pkg::*;

  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'(1) << EN_BIT;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) ctrl_d = wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign rdata = ctrl_q;
  assign en    = ctrl_q[EN_BIT];

  // R9: a register write is visible only after its clock edge
  a_r9_en_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/dmo_sram.sv
module dmo_sram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata_q   <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dmo_router.sv
module dmo_router #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SRAM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_ready,
  output logic               sram_we,
  output logic               sram_re,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  input  logic [DATA_W-1:0]  sram_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_ack
);
  import dmo_pkg::*;

  localparam int unsigned HI_W = ADDR_W - SRAM_AW;

  dmo_state_e        state_q, state_d;
  logic              ready_q, ready_d;
  logic              src_int_q, src_int_d;
  logic              bwe_q, bwe_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic [DATA_W-1:0] bwdata_q, bwdata_d;
  logic [DATA_W-1:0] ext_q, ext_d;

  logic strobe, go, hit;

  assign strobe = cpu_rd | cpu_wr;
  assign go     = strobe && (state_q == ST_IDLE);
  assign hit    = en && (cpu_addr[ADDR_W-1:SRAM_AW] == HI_W'(0));

  always_comb begin
    state_d   = state_q;
    ready_d   = 1'b0;
    src_int_d = src_int_q;
    bwe_d     = bwe_q;
    baddr_d   = baddr_q;
    bwdata_d  = bwdata_q;
    ext_d     = ext_q;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (hit) begin
            ready_d   = 1'b1;
            src_int_d = 1'b1;
          end else begin
            state_d  = ST_BUS;
            bwe_d    = cpu_wr;
            baddr_d  = cpu_addr;
            bwdata_d = cpu_wdata;
          end
        end
      end
      ST_BUS: begin
        if (bus_ack) begin
          state_d   = ST_IDLE;
          ready_d   = 1'b1;
          src_int_d = 1'b0;
          if (!bwe_q) ext_d = bus_rdata;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ready_q   <= 1'b0;
      src_int_q <= 1'b0;
      bwe_q     <= 1'b0;
      baddr_q   <= '0;
      bwdata_q  <= '0;
      ext_q     <= '0;
    end else begin
      state_q   <= state_d;
      ready_q   <= ready_d;
      src_int_q <= src_int_d;
      bwe_q     <= bwe_d;
      baddr_q   <= baddr_d;
      bwdata_q  <= bwdata_d;
      ext_q     <= ext_d;
    end
  end

  assign sram_we    = go && hit && cpu_wr;
  assign sram_re    = go && hit && !cpu_wr;
  assign sram_addr  = cpu_addr[SRAM_AW-1:0];
  assign sram_wdata = cpu_wdata;

  assign cpu_ready = ready_q;
  assign cpu_rdata = src_int_q ? sram_rdata : ext_q;
  assign bus_req   = (state_q == ST_BUS);
  assign bus_we    = bwe_q;
  assign bus_addr  = baddr_q;
  assign bus_wdata = bwdata_q;

  // R2, R5: internal hit completes next cycle with no bus activity
  a_r2_internal_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (go && hit) |=> (cpu_ready && !bus_req));

  // R3: a miss opens a bus request and withholds ready
  a_r3_external_req: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !hit) |=> (bus_req && !cpu_ready));

  // R7, R8: request and address held until acknowledge
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && !cpu_ready && $stable(bus_addr) && $stable(bus_we)));

  // R7: acknowledge ends the request and completes the access
  a_r7_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> (cpu_ready && !bus_req));

  // R8: no SRAM write while a bus access is pending
  a_r8_busy_no_sram: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !sram_we);
endmodule

// File: rtl/dmem_overlay.sv
module dmem_overlay #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SRAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic               en;
  logic               sram_we, sram_re;
  logic [SRAM_AW-1:0] sram_addr;
  logic [DATA_W-1:0]  sram_wdata, sram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dmo_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .en    (en)
  );

  dmo_sram #(.AW(SRAM_AW), .DW(DATA_W)) u_sram (
    .clk   (clk),
    .we    (sram_we),
    .re    (sram_re),
    .addr  (sram_addr),
    .wdata (sram_wdata),
    .rdata (sram_rdata)
  );

  dmo_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRAM_AW(SRAM_AW)) u_router (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (en),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_rdata  (cpu_rdata),
    .cpu_ready  (cpu_ready),
    .sram_we    (sram_we),
    .sram_re    (sram_re),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_rdata (sram_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ack    (bus_ack)
  );
endmodule

// File: tb/sim_dmem_overlay.sv
module sim_dmem_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SAW = 10;
  localparam int DEPTH = 1 << SAW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ready;
  logic          cfg_wr = 1'b0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mdl_mem [DEPTH];
  bit            mdl_ok  [DEPTH];
  bit            mdl_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_overlay #(.ADDR_W(AW), .DATA_W(DW), .SRAM_AW(SAW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  function automatic bit exp_internal(bit en, logic [AW-1:0] a);
    return en && (a < 16'h0400);
  endfunction

  function automatic logic [DW-1:0] bus_pattern(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cfg_write(input logic [DW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    mdl_en = d[0];
  endtask

  // one complete access, checked against the model
  task automatic access(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int lat, input string req);
    bit intl;
    intl = exp_internal(mdl_en, a);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd; cpu_rd = !wr; cpu_wr = wr;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    if (intl) begin
      chk(req, "internal ready/req", {cpu_ready, bus_req}, 2'b10);
      if (wr) begin
        mdl_mem[a[SAW-1:0]] = wd;
        mdl_ok[a[SAW-1:0]]  = 1'b1;
      end else if (mdl_ok[a[SAW-1:0]]) begin
        chk(req, "internal rdata", cpu_rdata, mdl_mem[a[SAW-1:0]]);
      end
    end else begin
      chk(req, "ext req/ready/we", {bus_req, cpu_ready, bus_we}, {2'b10, wr});
      chk(req, "ext addr", bus_addr, a);
      if (wr) chk(req, "ext wdata", bus_wdata, wd);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(req, "ext hold", {bus_req, cpu_ready, bus_addr}, {2'b10, a});
      end
      bus_ack = 1'b1; bus_rdata = bus_pattern(a);
      @(negedge clk);
      bus_ack = 1'b0; bus_rdata = 8'h00;
      chk(req, "ext done ready/req", {cpu_ready, bus_req}, 2'b10);
      if (!wr) chk(req, "ext rdata", cpu_rdata, bus_pattern(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE1));
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "reset outputs", {cpu_ready, bus_req, cfg_rdata}, 10'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "cfg after reset", cfg_rdata, 8'h00);

    // R1: everything external after reset
    access(1'b0, 16'h0000, 8'h00, 1, "R1");
    access(1'b1, 16'h03FF, 8'h3C, 0, "R1");

    // R6: only bit 0 is writable
    cfg_write(8'hFE);
    chk("R6", "reserved bits ignored", cfg_rdata, 8'h00);
    cfg_write(8'hFF);
    chk("R6", "enable bit only", cfg_rdata, 8'h01);

    // R2, R5: internal hits at both ends of the window
    access(1'b1, 16'h0000, 8'h11, 0, "R2");
    access(1'b1, 16'h03FF, 8'h22, 0, "R2");
    access(1'b0, 16'h0000, 8'h00, 0, "R5");
    access(1'b0, 16'h03FF, 8'h00, 0, "R5");

    // R3: boundary and top of space go external
    access(1'b0, 16'h0400, 8'h00, 2, "R3");
    access(1'b1, 16'hFFFF, 8'h77, 3, "R3");

    // R7: several acknowledge latencies
    access(1'b0, 16'h8123, 8'h00, 0, "R7");
    access(1'b0, 16'h4567, 8'h00, 5, "R7");

    // R4: contents survive disable/enable with bus traffic
    access(1'b1, 16'h0155, 8'hC3, 0, "R4");
    cfg_write(8'h00);
    access(1'b1, 16'h0155, 8'h99, 1, "R4");
    cfg_write(8'h01);
    access(1'b0, 16'h0155, 8'h00, 0, "R4");
    access(1'b0, 16'h03FF, 8'h00, 0, "R4");

    // R8: strobe during a pending bus access is ignored
    access(1'b1, 16'h0001, 8'h5A, 0, "R8");
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    cpu_addr = 16'h0001; cpu_wdata = 8'hEE; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R8", "pending unchanged", {bus_req, cpu_ready, bus_we, bus_addr}, {3'b100, 16'h8000});
    bus_ack = 1'b1; bus_rdata = bus_pattern(16'h8000);
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R8", "single completion", {cpu_ready, bus_req, cpu_rdata}, {2'b10, bus_pattern(16'h8000)});
    @(negedge clk);
    chk("R8", "no second access", {cpu_ready, bus_req}, 2'b00);
    access(1'b0, 16'h0001, 8'h00, 0, "R8");

    // R9: strobe in same cycle as enable write uses old value
    cfg_write(8'h00);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h01;
    cpu_addr = 16'h0010; cpu_rd = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cpu_rd = 1'b0;
    chk("R9", "old enable routes external", {bus_req, cpu_ready, bus_addr}, {2'b10, 16'h0010});
    bus_ack = 1'b1; bus_rdata = bus_pattern(16'h0010);
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R9", "external completes", {cpu_ready, cpu_rdata}, {1'b1, bus_pattern(16'h0010)});
    mdl_en = 1'b1;
    access(1'b0, 16'h0001, 8'h00, 0, "R9");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      int r;
      r = $urandom;
      if ((r % 16) == 0) cfg_write(DW'($urandom));
      if ($urandom % 2) a = AW'($urandom % DEPTH);
      else              a = AW'(16'h0400 + ($urandom % 16'hFC00));
      access(($urandom % 2) == 1, a, DW'($urandom), $urandom % 4,
             exp_internal(mdl_en, a) ? "R2" : "R3");
    end

    summary();
    $finish;
  end
endmodule